// File: doc/BRIEF.md
# In-Order Multi-Device Dispatch and Retire Unit

This block sits on the host side of a shared streaming bus that serves up to four packet-processing devices. When the host offers a command, the block picks a target device from the command's session number and raises that device's write strobe for one cycle. It records the chosen device in a small circular index table, and it returns an 8-bit tag that the host writes into the command's pass-through field. The tag carries both the device number and the table slot.

Results come back in the order the commands were issued. The block drives the read strobe of the device named by the oldest outstanding table entry. When a result arrives, the block compares the echoed tag with the tag it expects for that entry. A matching result retires the entry and advances the table head. A mismatch sets a sticky error flag and leaves the head where it is, so a later correct result can still retire that entry.

Top module: `iod_dispatch_retire`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cmd_ready is 1, and wr_sel, rd_sel, retire_valid and tag_err are all 0.
- R2: A command is accepted at a clock edge where cmd_valid and cmd_ready are both 1. The target device is d = cmd_session[15:14]. In the cycle after acceptance wr_sel is one-hot with bit d set. In every other cycle wr_sel is 0.
- R3: In the cycle after acceptance, wr_tag equals {d[1:0], 3'b000, n[2:0]}, where n counts the commands accepted since reset.
- R4: After eight commands are outstanding, cmd_ready is 0. A cmd_valid offered while cmd_ready is 0 has no effect: wr_sel stays 0 and no table entry is used.
- R5: rd_sel is combinational. When ret_req is 1 and at least one entry is outstanding, rd_sel is one-hot with the bit of the oldest entry's device set. Otherwise rd_sel is 0.
- R6: A res_valid pulse whose res_tag equals the oldest entry's tag (the same layout as R3) retires that entry. In the next cycle retire_valid is 1 and retire_dev holds that entry's device.
- R7: A res_valid pulse with any other res_tag, while entries are outstanding, sets tag_err in the next cycle. It produces no retire_valid and does not advance the head, so the same entry can still be retired afterwards.
- R8: A res_valid pulse while no entry is outstanding is ignored: it produces neither retire_valid nor a change in tag_err.
- R9: Entries retire strictly in the order they were accepted, including after the table slots wrap around.
- R10: Once set, tag_err stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_session | input | 16 | Session number of the offered command |
| cmd_ready | output | 1 | The table has a free slot |
| wr_sel | output | 4 | One-hot write strobe for the target device |
| wr_tag | output | 8 | Tag for the pass-through field (device, zero pad, slot) |
| ret_req | input | 1 | Host wants to read the next result |
| rd_sel | output | 4 | One-hot read strobe for the device at the table head |
| res_valid | input | 1 | An echoed result tag is present |
| res_tag | input | 8 | Pass-through value returned with the result |
| retire_valid | output | 1 | The head entry retired in the previous cycle |
| retire_dev | output | 2 | Device of the retired entry |
| tag_err | output | 1 | Sticky tag-mismatch flag |

## Verification
The assertions assume that cmd_valid, cmd_session, ret_req, res_valid and res_tag are sampled only at rising clock edges. They also assume that res_valid is a single-cycle pulse per result. The bench therefore changes every input at the falling edge and holds it for exactly one rising edge. It raises res_valid at most once per retire attempt and returns each result only after the matching command has been accepted.

// File: rtl/iod_pkg.sv
package iod_pkg;
  localparam int TAG_W    = 8;
  localparam int DEVF_W   = 2;
  localparam int SLOTF_W  = TAG_W - DEVF_W;

  typedef logic [DEVF_W-1:0]  dev_field_t;
  typedef logic [SLOTF_W-1:0] slot_field_t;
  typedef logic [TAG_W-1:0]   tag_t;

  function automatic tag_t make_tag(dev_field_t dev, slot_field_t slot);
    return {dev, slot};
  endfunction
endpackage

// File: rtl/iod_onehot.sv
module iod_onehot #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         en,
  input  logic [W-1:0] sel,
  output logic [N-1:0] hot
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot[i] = en && (sel == W'(i));
  end
endmodule

// File: rtl/iod_index_table.sv
module iod_index_table #(
  parameter int DEPTH = 8,
  parameter int DEV_W = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DEV_W-1:0] push_dev,
  input  logic             pop,
  output logic [DEV_W-1:0] head_dev,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [DEV_W-1:0] slot_dev [DEPTH];

  assign tail_idx = wr_ptr_q[IDX_W-1:0];
  assign head_idx = rd_ptr_q[IDX_W-1:0];
  assign empty    = (wr_ptr_q == rd_ptr_q);
  assign full     = (wr_ptr_q[IDX_W] != rd_ptr_q[IDX_W]) &&
                    (wr_ptr_q[IDX_W-1:0] == rd_ptr_q[IDX_W-1:0]);
  assign head_dev = slot_dev[head_idx];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push && !full)  wr_ptr_d = wr_ptr_q + PTR_W'(1);
    if (pop && !empty)  rd_ptr_d = rd_ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) slot_dev[tail_idx] <= push_dev;
  end
endmodule

// File: rtl/iod_tag_check.sv
module iod_tag_check
  import iod_pkg::*;
#(
  parameter int DEV_W = 2,
  parameter int IDX_W = 3
) (
  input  logic [DEV_W-1:0] head_dev,
  input  logic [IDX_W-1:0] head_idx,
  input  tag_t             res_tag,
  output tag_t             exp_tag,
  output logic             match
);
  dev_field_t  dev_ext;
  slot_field_t slot_ext;

  always_comb begin
    dev_ext  = '0;
    slot_ext = '0;
    dev_ext[DEV_W-1:0]  = head_dev;
    slot_ext[IDX_W-1:0] = head_idx;
    exp_tag  = make_tag(dev_ext, slot_ext);
    match    = (res_tag == exp_tag);
  end
endmodule

// File: rtl/iod_dispatch_retire.sv
module iod_dispatch_retire
  import iod_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEPTH   = 8,
  parameter int SESS_W  = 16,
  localparam int DEV_W  = $clog2(NUM_DEV),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [SESS_W-1:0]  cmd_session,
  output logic               cmd_ready,
  output logic [NUM_DEV-1:0] wr_sel,
  output logic [TAG_W-1:0]   wr_tag,
  input  logic               ret_req,
  output logic [NUM_DEV-1:0] rd_sel,
  input  logic               res_valid,
  input  logic [TAG_W-1:0]   res_tag,
  output logic               retire_valid,
  output logic [DEVF_W-1:0]  retire_dev,
  output logic               tag_err
);
  logic             accept, retire, mismatch;
  logic [DEV_W-1:0] cmd_dev, head_dev;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             full, empty, match;
  tag_t             exp_tag, new_tag;
  logic [NUM_DEV-1:0] wr_hot;

  logic [NUM_DEV-1:0] wr_sel_q, wr_sel_d;
  tag_t               wr_tag_q, wr_tag_d;
  logic               ret_v_q, ret_v_d;
  dev_field_t         ret_dev_q, ret_dev_d;
  logic               err_q, err_d;

  assign cmd_dev   = cmd_session[SESS_W-1 -: DEV_W];
  assign cmd_ready = !full;
  assign accept    = cmd_valid && !full;

  iod_index_table #(.DEPTH(DEPTH), .DEV_W(DEV_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_dev (cmd_dev),
    .pop      (retire),
    .head_dev (head_dev),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .full     (full),
    .empty    (empty)
  );

  iod_tag_check #(.DEV_W(DEV_W), .IDX_W(IDX_W)) u_check (
    .head_dev (head_dev),
    .head_idx (head_idx),
    .res_tag  (res_tag),
    .exp_tag  (exp_tag),
    .match    (match)
  );

  iod_onehot #(.N(NUM_DEV), .W(DEV_W)) u_wr_dec (
    .en  (accept),
    .sel (cmd_dev),
    .hot (wr_hot)
  );

  iod_onehot #(.N(NUM_DEV), .W(DEV_W)) u_rd_dec (
    .en  (ret_req && !empty),
    .sel (head_dev),
    .hot (rd_sel)
  );

  assign retire   = res_valid && !empty && match;
  assign mismatch = res_valid && !empty && !match;

  always_comb begin
    dev_field_t  d_ext;
    slot_field_t s_ext;
    d_ext = '0;
    s_ext = '0;
    d_ext[DEV_W-1:0] = cmd_dev;
    s_ext[IDX_W-1:0] = tail_idx;
    new_tag = make_tag(d_ext, s_ext);
  end

  always_comb begin
    wr_sel_d  = wr_hot;
    wr_tag_d  = wr_tag_q;
    ret_v_d   = retire;
    ret_dev_d = ret_dev_q;
    err_d     = err_q || mismatch;
    if (accept) wr_tag_d = new_tag;
    if (retire) begin
      ret_dev_d = '0;
      ret_dev_d[DEV_W-1:0] = head_dev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel_q  <= '0;
      wr_tag_q  <= '0;
      ret_v_q   <= 1'b0;
      ret_dev_q <= '0;
      err_q     <= 1'b0;
    end else begin
      wr_sel_q  <= wr_sel_d;
      wr_tag_q  <= wr_tag_d;
      ret_v_q   <= ret_v_d;
      ret_dev_q <= ret_dev_d;
      err_q     <= err_d;
    end
  end

  assign wr_sel       = wr_sel_q;
  assign wr_tag       = wr_tag_q;
  assign retire_valid = ret_v_q;
  assign retire_dev   = ret_dev_q;
  assign tag_err      = err_q;
endmodule

// File: rtl/iod_dispatch_retire_chk.sv
module iod_dispatch_retire_chk #(
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [NUM_DEV-1:0] wr_sel,
  input logic               ret_req,
  input logic [NUM_DEV-1:0] rd_sel,
  input logic               res_valid,
  input logic               retire_valid,
  input logic               tag_err
);
  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R2
  wr_only_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel != '0) |-> $past(cmd_valid && cmd_ready));

  // R4
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (wr_sel == '0));

  // R5
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel));

  // R5
  rd_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel != '0) |-> ret_req);

  // R6
  retire_needs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> $past(res_valid));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err |=> tag_err);
endmodule

bind iod_dispatch_retire iod_dispatch_retire_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .wr_sel       (wr_sel),
  .ret_req      (ret_req),
  .rd_sel       (rd_sel),
  .res_valid    (res_valid),
  .retire_valid (retire_valid),
  .tag_err      (tag_err)
);

// File: tb/tb_iod_dispatch_retire.sv
module tb_iod_dispatch_retire;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_session;
  logic        cmd_ready;
  logic [3:0]  wr_sel;
  logic [7:0]  wr_tag;
  logic        ret_req;
  logic [3:0]  rd_sel;
  logic        res_valid;
  logic [7:0]  res_tag;
  logic        retire_valid;
  logic [1:0]  retire_dev;
  logic        tag_err;

  always #5 clk = ~clk;

  iod_dispatch_retire dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_session(cmd_session),
    .cmd_ready(cmd_ready), .wr_sel(wr_sel), .wr_tag(wr_tag), .ret_req(ret_req),
    .rd_sel(rd_sel), .res_valid(res_valid), .res_tag(res_tag),
    .retire_valid(retire_valid), .retire_dev(retire_dev), .tag_err(tag_err)
  );

  int checks = 0;
  int errors = 0;
  int disp_n = 0;
  int ret_n  = 0;
  bit err_model = 1'b0;
  bit done = 1'b0;
  logic [1:0] q_dev [8];

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dispatch(input logic [15:0] s);
    logic [1:0] d;
    bit room;
    d = s[15:14];
    room = (disp_n - ret_n) < 8;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_session = s;
    #1 check_eq("R4 cmd_ready", 32'(cmd_ready), 32'(room));
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    if (room) begin
      check_eq("R2 wr_sel", 32'(wr_sel), 32'(4'b0001 << d));
      check_eq("R3 wr_tag", 32'(wr_tag), 32'({d, 3'b000, 3'(disp_n % 8)}));
      q_dev[disp_n % 8] = d;
      disp_n++;
    end else begin
      check_eq("R4 wr_sel while full", 32'(wr_sel), 32'd0);
    end
  endtask

  task automatic retire_try(input logic [7:0] xor_mask);
    bit empty;
    bit good;
    logic [7:0] exp_tag;
    empty = (disp_n == ret_n);
    exp_tag = {q_dev[ret_n % 8], 3'b000, 3'(ret_n % 8)};
    @(negedge clk);
    ret_req = 1'b1;
    #1 check_eq("R5 rd_sel", 32'(rd_sel), empty ? 32'd0 : 32'(4'b0001 << q_dev[ret_n % 8]));
    res_valid = 1'b1;
    res_tag = exp_tag ^ xor_mask;
    good = !empty && (xor_mask == 8'h00);
    @(posedge clk);
    #1;
    ret_req = 1'b0;
    res_valid = 1'b0;
    check_eq(empty ? "R8 retire_valid on empty" : "R6 retire_valid",
             32'(retire_valid), 32'(good));
    if (good) begin
      check_eq("R9 retire order", 32'(retire_dev), 32'(q_dev[ret_n % 8]));
      ret_n++;
    end
    if (!empty && !good) err_model = 1'b1;
    check_eq("R7 R10 tag_err", 32'(tag_err), 32'(err_model));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_session = '0;
    ret_req = 1'b0;
    res_valid = 1'b0;
    res_tag = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check_eq("R1 ready", 32'(cmd_ready), 32'd1);
    check_eq("R1 wr_sel", 32'(wr_sel), 32'd0);
    check_eq("R1 retire_valid", 32'(retire_valid), 32'd0);
    check_eq("R1 tag_err", 32'(tag_err), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_eq("R1 ready after release", 32'(cmd_ready), 32'd1);
    check_eq("R1 rd_sel", 32'(rd_sel), 32'd0);

    // R8: result on empty table
    retire_try(8'h00);
    retire_try(8'h15);

    // R4: fill the table, then one more offer is refused
    for (int i = 0; i < 9; i++) dispatch(16'((((i * 3) % 4) << 14) | (i * 97)));
    // R6 R9: drain in order
    for (int i = 0; i < 8; i++) retire_try(8'h00);
    retire_try(8'h00);

    // R2 R3 R9: sweep session space with wraparound of slots
    for (int r = 0; r < 40; r++) begin
      for (int j = 0; j < 3; j++) dispatch(16'(r * 1637 + j * 21841));
      for (int j = 0; j < 2; j++) retire_try(8'h00);
    end
    while (ret_n != disp_n) retire_try(8'h00);

    // R7: wrong slot, wrong device, then the correct tag still retires
    dispatch(16'hC123);
    retire_try(8'h01);
    retire_try(8'h40);
    retire_try(8'h00);
    // R10 and R8: flag held, empty result ignored
    retire_try(8'h00);
    dispatch(16'h4000);
    retire_try(8'h00);
    check_eq("R10 tag_err held", 32'(tag_err), 32'd1);

    finish_run();
  end
endmodule